// File: doc/BRIEF.md
# Reset Strap Capture and Clock-Speed Controller

This block samples board straps when power-good comes up and sets the default of the bus-clock slow-select bit. It also latches a hot-plug-enable status and an external-arbiter enable default. The slow default comes from a timed pulse on the compatibility strap. The strap must be high when power-good rises, must stay high for at least `HOLD_CYC` reference-clock edges, and must then fall before the link reset is released. That sequence sets the bit to 0 (slow). Any other pattern leaves it at 1 (normal).

After power-up, software may write the slow-select bit, but the applied clock select does not follow at once. Outside hot-plug mode, the written value waits until the secondary-bus-reset control bit rises, and only the most recent write is applied. In hot-plug mode, a write of 0 slows the clock on the next reference edge. A read-only status bit reports the reduced speed, and it changes only when a secondary bus reset applies a value. A small decoder turns the bus mode and the applied select into the resulting clock rate in MHz.

All pins are plain control and status levels sampled on the free-running reference clock. No stream interface is present, so no back-pressure rules apply.

Top module: `strap_clk_ctrl`

## Requirements
- R1: While `pwr_good` is low (cold reset), `clk_slow_n`=1, `speed_slow`=0, `hp_en`=0 and `ext_arb_n`=1.
- R2: The strap pattern sets the slow bit to 0 at the first `link_rst_n` rising edge after power-good rises. The pattern is: `compat_strap` high at the first reference edge after `pwr_good` rises, high for at least `HOLD_CYC` (default 12) consecutive edges, then low before `link_rst_n` rises. The result is `clk_slow_n`=0 and `speed_slow`=1.
- R3: Any other strap pattern leaves the bit at 1 after link release (`clk_slow_n`=1, `speed_slow`=0). This covers a strap held too briefly, a strap that never falls and a strap low at power-good.
- R4: A warm reset does not recapture the straps, and all outputs keep their values. A warm reset is a `link_rst_n` low pulse while `pwr_good` stays high.
- R5: `hp_en` latches the inverse of `hp_req_strap_n` at the first edge after `pwr_good` rises and then holds through link resets and strap changes.
- R6: `ext_arb_n` loads `arb_strap` at the first edge after `pwr_good` rises. It is then changed only by `wr_arb_en` (taking `wr_data`), and link resets do not affect it.
- R7: With `hp_mode`=0, a write of the slow bit (`wr_slow_en`) does not change `clk_slow_n` or `speed_slow`. On the next rising edge of `sbr_ctl`, both take the written value one edge later, with `speed_slow` = inverse of `clk_slow_n`.
- R8: When several writes precede an `sbr_ctl` rising edge, only the last one is applied. A write in the same cycle as the `sbr_ctl` rise is the one applied.
- R9: With `hp_mode`=1, a write of 0 drives `clk_slow_n` to 0 at the next edge while `speed_slow` holds. A write of 1 in hot-plug mode still waits for `sbr_ctl`.
- R10: `bus_mhz` is set by `bus_mode` and the applied select. Code 0 (conventional 33) gives 33, or 25 when slow. Codes 1 (conventional 66) and 2 (PCI-X 66) give 66, or 50 when slow. Code 3 (fast PCI-X) gives 133 whatever the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Power good; low is cold reset (async clear) |
| link_rst_n | input | 1 | Link reset, active low |
| compat_strap | input | 1 | Compatibility strap carrying the slow-default pulse |
| hp_req_strap_n | input | 1 | Hot-plug request strap, active low |
| arb_strap | input | 1 | Arbiter strap giving the external-arbiter default |
| hp_mode | input | 1 | Bus currently in hot-plug mode |
| sbr_ctl | input | 1 | Secondary-bus-reset control bit |
| wr_slow_en | input | 1 | Write strobe for the slow-select bit |
| wr_arb_en | input | 1 | Write strobe for the external-arbiter bit |
| wr_data | input | 1 | Write data bit |
| bus_mode | input | 2 | Bus mode code (0..3, see R10) |
| clk_slow_n | output | 1 | Applied clock select, 0 = reduced speed |
| speed_slow | output | 1 | Read-only reduced-speed status |
| hp_en | output | 1 | Hot-plug enable status |
| ext_arb_n | output | 1 | External arbiter enable, active low |
| bus_mhz | output | 8 | Resulting bus clock rate in MHz |

## Verification
A software write of the slow bit and the rising edge of the secondary-bus-reset bit can land on the same reference edge. The bench drives `wr_slow_en` and `sbr_ctl` high on the same falling edge, with data opposite to the stored value. It then checks that the written value, not the stale one, reaches both `clk_slow_n` and `speed_slow` one edge later. The same pairing is repeated in hot-plug mode, where the immediate path and the reset-applied path both act on the select.

// File: rtl/strapclk_pkg.sv
package strapclk_pkg;

  typedef enum logic [1:0] {
    BUS_CONV33  = 2'd0,
    BUS_CONV66  = 2'd1,
    BUS_PCIX66  = 2'd2,
    BUS_PCIX_HI = 2'd3
  } bus_mode_e;

  localparam int MHZ_W = 8;

  // Rate for a mode and an applied select (slow_n = 0 reduces speed).
  function automatic logic [MHZ_W-1:0] rate_mhz(bus_mode_e m, logic slow_n);
    logic [MHZ_W-1:0] r;
    case (m)
      BUS_CONV33:  r = slow_n ? MHZ_W'(33) : MHZ_W'(25);
      BUS_CONV66:  r = slow_n ? MHZ_W'(66) : MHZ_W'(50);
      BUS_PCIX66:  r = slow_n ? MHZ_W'(66) : MHZ_W'(50);
      default:     r = MHZ_W'(133);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int HOLD_CYC = 12
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic link_rst_n,
  input  logic compat_strap,
  input  logic hp_req_strap_n,
  input  logic arb_strap,
  input  logic wr_arb_en,
  input  logic wr_data,
  output logic cap_stb,
  output logic cap_slow_n,
  output logic hp_en,
  output logic ext_arb_n
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          pg_q, lr_q;
  logic          tracking, armed, qual, done;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          pg_rise, lr_rise;

  assign pg_rise    = pwr_good & ~pg_q;
  assign lr_rise    = link_rst_n & ~lr_q;
  assign cap_stb    = lr_rise & ~done;
  assign cap_slow_n = ~qual;
  assign cnt_nxt    = cnt + CW'(1);

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      pg_q      <= 1'b0;
      lr_q      <= 1'b0;
      tracking  <= 1'b0;
      armed     <= 1'b0;
      qual      <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      hp_en     <= 1'b0;
      ext_arb_n <= 1'b1;
    end else begin
      pg_q <= 1'b1;
      lr_q <= link_rst_n;
      if (pg_rise) begin
        hp_en     <= ~hp_req_strap_n;
        ext_arb_n <= arb_strap;
        tracking  <= compat_strap;
        cnt       <= compat_strap ? CW'(1) : '0;
        armed     <= compat_strap && (HOLD_CYC <= 1);
        qual      <= 1'b0;
      end else begin
        if (!done) begin
          if (tracking && !armed) begin
            if (compat_strap) begin
              cnt <= cnt_nxt;
              if (cnt_nxt >= CW'(HOLD_CYC)) armed <= 1'b1;
            end else begin
              tracking <= 1'b0;
            end
          end
          if (armed && !compat_strap) qual <= 1'b1;
        end
        if (wr_arb_en) ext_arb_n <= wr_data;
      end
      if (cap_stb) done <= 1'b1;
    end
  end

  // R5: hot-plug status holds once power is up
  p_hpen_hold_r5: assert property (@(posedge clk) disable iff (!pwr_good)
    pg_q |=> $stable(hp_en));

  // R6: arbiter bit moves only on a software write after power-up
  p_arb_hold_r6: assert property (@(posedge clk) disable iff (!pwr_good)
    (pg_q && !wr_arb_en) |=> $stable(ext_arb_n));

  // R4: a capture never repeats within one power cycle
  p_single_capture_r4: assert property (@(posedge clk) disable iff (!pwr_good)
    cap_stb |=> !cap_stb);

endmodule

// File: rtl/speed_ctrl.sv
module speed_ctrl (
  input  logic clk,
  input  logic pwr_good,
  input  logic cap_stb,
  input  logic cap_slow_n,
  input  logic hp_mode,
  input  logic sbr_ctl,
  input  logic wr_en,
  input  logic wr_data,
  output logic act_slow_n,
  output logic stat_slow
);
  logic reg_slow_n;
  logic sbr_q;
  logic sbr_rise;
  logic fast_slow;
  logic apply_val;

  assign sbr_rise  = sbr_ctl & ~sbr_q;
  assign fast_slow = hp_mode & wr_en & ~wr_data;
  assign apply_val = wr_en ? wr_data : reg_slow_n;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      reg_slow_n <= 1'b1;
      act_slow_n <= 1'b1;
      stat_slow  <= 1'b0;
      sbr_q      <= 1'b0;
    end else begin
      sbr_q <= sbr_ctl;
      if (cap_stb) begin
        reg_slow_n <= cap_slow_n;
        act_slow_n <= cap_slow_n;
        stat_slow  <= ~cap_slow_n;
      end else begin
        if (wr_en) reg_slow_n <= wr_data;
        if (sbr_rise) begin
          act_slow_n <= apply_val;
          stat_slow  <= ~apply_val;
        end else if (fast_slow) begin
          act_slow_n <= 1'b0;
        end
      end
    end
  end

  // R7: select is held unless capture, reset edge, or hot-plug slow write
  p_act_hold_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    (!cap_stb && !sbr_ctl && !fast_slow) |=> $stable(act_slow_n));

  // R9: status only moves on capture or a bus-reset edge
  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!pwr_good)
    (!cap_stb && !sbr_rise) |=> $stable(stat_slow));

  // R9: hot-plug slow write takes effect on the next edge
  p_hp_fast_r9: assert property (@(posedge clk) disable iff (!pwr_good)
    (fast_slow && !cap_stb) |=> !act_slow_n);

  // R8: after a bus-reset edge select and status agree
  p_sbr_agree_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    (sbr_rise && !cap_stb) |=> (act_slow_n == !stat_slow));

endmodule

// File: rtl/speed_map.sv
module speed_map
  import strapclk_pkg::*;
(
  input  logic [1:0]       bus_mode,
  input  logic             slow_n,
  output logic [MHZ_W-1:0] mhz
);
  always_comb begin
    mhz = rate_mhz(bus_mode_e'(bus_mode), slow_n);
    // R10: fastest mode ignores the select
    p_fast_unaffected_r10: assert (bus_mode != 2'd3 || mhz == MHZ_W'(133));
  end
endmodule

// File: rtl/strap_clk_ctrl.sv
module strap_clk_ctrl
  import strapclk_pkg::*;
#(
  parameter int HOLD_CYC = 12
) (
  input  logic             clk,
  input  logic             pwr_good,
  input  logic             link_rst_n,
  input  logic             compat_strap,
  input  logic             hp_req_strap_n,
  input  logic             arb_strap,
  input  logic             hp_mode,
  input  logic             sbr_ctl,
  input  logic             wr_slow_en,
  input  logic             wr_arb_en,
  input  logic             wr_data,
  input  logic [1:0]       bus_mode,
  output logic             clk_slow_n,
  output logic             speed_slow,
  output logic             hp_en,
  output logic             ext_arb_n,
  output logic [MHZ_W-1:0] bus_mhz
);
  logic cap_stb, cap_slow_n;

  strap_capture #(.HOLD_CYC(HOLD_CYC)) u_cap (
    .clk            (clk),
    .pwr_good       (pwr_good),
    .link_rst_n     (link_rst_n),
    .compat_strap   (compat_strap),
    .hp_req_strap_n (hp_req_strap_n),
    .arb_strap      (arb_strap),
    .wr_arb_en      (wr_arb_en),
    .wr_data        (wr_data),
    .cap_stb        (cap_stb),
    .cap_slow_n     (cap_slow_n),
    .hp_en          (hp_en),
    .ext_arb_n      (ext_arb_n)
  );

  speed_ctrl u_spd (
    .clk        (clk),
    .pwr_good   (pwr_good),
    .cap_stb    (cap_stb),
    .cap_slow_n (cap_slow_n),
    .hp_mode    (hp_mode),
    .sbr_ctl    (sbr_ctl),
    .wr_en      (wr_slow_en),
    .wr_data    (wr_data),
    .act_slow_n (clk_slow_n),
    .stat_slow  (speed_slow)
  );

  speed_map u_map (
    .bus_mode (bus_mode),
    .slow_n   (clk_slow_n),
    .mhz      (bus_mhz)
  );

endmodule

// File: tb/tb_strap_clk_ctrl.sv
module tb_strap_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, link_rst_n = 1'b0;
  logic compat_strap = 1'b0, hp_req_strap_n = 1'b1, arb_strap = 1'b1;
  logic hp_mode = 1'b0, sbr_ctl = 1'b0;
  logic wr_slow_en = 1'b0, wr_arb_en = 1'b0, wr_data = 1'b0;
  logic [1:0] bus_mode = 2'd0;
  logic clk_slow_n, speed_slow, hp_en, ext_arb_n;
  logic [7:0] bus_mhz;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_clk_ctrl #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .pwr_good(pwr_good), .link_rst_n(link_rst_n),
    .compat_strap(compat_strap), .hp_req_strap_n(hp_req_strap_n),
    .arb_strap(arb_strap), .hp_mode(hp_mode), .sbr_ctl(sbr_ctl),
    .wr_slow_en(wr_slow_en), .wr_arb_en(wr_arb_en), .wr_data(wr_data),
    .bus_mode(bus_mode), .clk_slow_n(clk_slow_n), .speed_slow(speed_slow),
    .hp_en(hp_en), .ext_arb_n(ext_arb_n), .bus_mhz(bus_mhz)
  );

  // R10 table: mode, select, expected rate
  typedef struct packed { logic [1:0] mode; logic slow_n; logic [7:0] mhz; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b1, 8'd33},  '{2'd1, 1'b1, 8'd66},
    '{2'd2, 1'b1, 8'd66},  '{2'd3, 1'b1, 8'd133},
    '{2'd0, 1'b0, 8'd25},  '{2'd1, 1'b0, 8'd50},
    '{2'd2, 1'b0, 8'd50},  '{2'd3, 1'b0, 8'd133}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_slow(input logic v);
    @(negedge clk); wr_slow_en = 1'b1; wr_data = v;
    @(negedge clk); wr_slow_en = 1'b0;
  endtask

  task automatic pulse_sbr();
    @(negedge clk); sbr_ctl = 1'b1;
    @(negedge clk); sbr_ctl = 1'b0;
  endtask

  // cold reset then power-up with the given strap pulse on compat
  task automatic power_up(input int high_cyc, input bit drop, input logic hpreq_n, input logic arb);
    @(negedge clk); pwr_good = 1'b0; link_rst_n = 1'b0;
    compat_strap = (high_cyc > 0); hp_req_strap_n = hpreq_n; arb_strap = arb;
    edges(3);
    pwr_good = 1'b1;
    if (high_cyc > 0) edges(high_cyc);
    if (drop) compat_strap = 1'b0;
    edges(3);
    link_rst_n = 1'b1;
    edges(2);
  endtask

  initial begin
    edges(4);
    // R1 reset state
    chk("R1 clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    chk("R1 speed_slow", {7'd0, speed_slow}, 8'd0);
    chk("R1 hp_en", {7'd0, hp_en}, 8'd0);
    chk("R1 ext_arb_n", {7'd0, ext_arb_n}, 8'd1);

    // R2 valid pattern, R5 hot-plug strap active, R6 arbiter strap 0
    power_up(HOLD + 8, 1, 1'b0, 1'b0);
    chk("R2 clk_slow_n", {7'd0, clk_slow_n}, 8'd0);
    chk("R2 speed_slow", {7'd0, speed_slow}, 8'd1);
    chk("R5 hp_en", {7'd0, hp_en}, 8'd1);
    chk("R6 ext_arb_n", {7'd0, ext_arb_n}, 8'd0);

    // R4 warm reset with changed straps and a fresh pulse
    @(negedge clk); link_rst_n = 1'b0; hp_req_strap_n = 1'b1; arb_strap = 1'b1;
    compat_strap = 1'b0; edges(20); link_rst_n = 1'b1; edges(3);
    chk("R4 clk_slow_n", {7'd0, clk_slow_n}, 8'd0);
    chk("R4 speed_slow", {7'd0, speed_slow}, 8'd1);
    chk("R4/R5 hp_en", {7'd0, hp_en}, 8'd1);
    chk("R4/R6 ext_arb_n", {7'd0, ext_arb_n}, 8'd0);

    // R1 during a second cold reset
    @(negedge clk); pwr_good = 1'b0; edges(2);
    chk("R1 cold clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    chk("R1 cold hp_en", {7'd0, hp_en}, 8'd0);
    chk("R1 cold ext_arb_n", {7'd0, ext_arb_n}, 8'd1);

    // R3 short pulse
    power_up(5, 1, 1'b1, 1'b1);
    chk("R3 short clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    chk("R3 short speed_slow", {7'd0, speed_slow}, 8'd0);
    chk("R5 hp_en strap off", {7'd0, hp_en}, 8'd0);
    chk("R6 ext_arb_n strap 1", {7'd0, ext_arb_n}, 8'd1);
    // R3 strap never falls
    power_up(HOLD + 8, 0, 1'b1, 1'b1);
    chk("R3 nofall clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    // R3 strap low at power-good
    power_up(0, 0, 1'b1, 1'b1);
    chk("R3 low clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    compat_strap = 1'b0;

    // R7 pending write outside hot-plug
    hp_mode = 1'b0;
    wr_slow(1'b0); edges(3);
    chk("R7 pending clk_slow_n", {7'd0, clk_slow_n}, 8'd1);
    chk("R7 pending speed_slow", {7'd0, speed_slow}, 8'd0);
    @(negedge clk); sbr_ctl = 1'b1; @(negedge clk);
    chk("R7 applied clk_slow_n", {7'd0, clk_slow_n}, 8'd0);
    chk("R7 applied speed_slow", {7'd0, speed_slow}, 8'd1);
    sbr_ctl = 1'b0;

    // R8 last write wins
    wr_slow(1'b1); wr_slow(1'b0); wr_slow(1'b1);
    chk("R8 still pending", {7'd0, clk_slow_n}, 8'd0);
    pulse_sbr();
    chk("R8 last write", {7'd0, clk_slow_n}, 8'd1);
    // R8 write in same cycle as bus-reset rise
    @(negedge clk); wr_slow_en = 1'b1; wr_data = 1'b0; sbr_ctl = 1'b1;
    @(negedge clk); wr_slow_en = 1'b0; sbr_ctl = 1'b0;
    chk("R8 same-cycle clk_slow_n", {7'd0, clk_slow_n}, 8'd0);
    chk("R8 same-cycle speed_slow", {7'd0, speed_slow}, 8'd1);

    // R9 hot-plug: write 1 waits, write 0 immediate
    hp_mode = 1'b1;
    wr_slow(1'b1); edges(2);
    chk("R9 write1 waits", {7'd0, clk_slow_n}, 8'd0);
    pulse_sbr();
    chk("R9 write1 applied", {7'd0, clk_slow_n}, 8'd1);
    chk("R9 status normal", {7'd0, speed_slow}, 8'd0);
    wr_slow(1'b0);
    chk("R9 write0 immediate", {7'd0, clk_slow_n}, 8'd0);
    chk("R9 status held", {7'd0, speed_slow}, 8'd0);
    pulse_sbr();
    chk("R9 status after sbr", {7'd0, speed_slow}, 8'd1);
    // R9 same-cycle write 1 with bus-reset rise in hot-plug
    @(negedge clk); wr_slow_en = 1'b1; wr_data = 1'b1; sbr_ctl = 1'b1;
    @(negedge clk); wr_slow_en = 1'b0; sbr_ctl = 1'b0;
    chk("R9 hp same-cycle", {7'd0, clk_slow_n}, 8'd1);
    hp_mode = 1'b0;

    // R6 software write of arbiter bit, then warm reset
    @(negedge clk); wr_arb_en = 1'b1; wr_data = 1'b0;
    @(negedge clk); wr_arb_en = 1'b0;
    chk("R6 arb write", {7'd0, ext_arb_n}, 8'd0);
    link_rst_n = 1'b0; edges(4); link_rst_n = 1'b1; edges(2);
    chk("R6 arb after warm", {7'd0, ext_arb_n}, 8'd0);

    // R10 table walk
    for (int i = 0; i < 8; i++) begin
      if (clk_slow_n != VECS[i].slow_n) begin
        wr_slow(VECS[i].slow_n); pulse_sbr();
      end
      @(negedge clk); bus_mode = VECS[i].mode;
      #1;
      chk($sformatf("R10 vec%0d", i), bus_mhz, VECS[i].mhz);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule